// File: doc/BRIEF.md
# Fractional-Ratio Clock Crossing Strobe

This block sits in the fast clock domain of a pair of clocks whose frequencies differ by a programmable, possibly non-integer ratio. It does not see the slow clock. Instead it tracks slow-clock timing with an exact integer residue kept in eighths of a fast period. For every slow cycle it raises a strobe that is one fast cycle wide, on the fast edge closest to the middle of that slow cycle. Data can cross in either direction in that cycle with the widest setup and hold margins.

An alignment input restarts the pattern and loads the ratio. The ratio is given in quarter steps, from 2.00 to 5.25 fast cycles per slow cycle. The same strobe drives two capture registers. One holds fast-domain data for the slow side to sample. The other takes slow-domain data into the fast domain.

Top module: `frac_xing_strobe`

## Requirements
- R1: While `rst_n` is low, `xfer_en_o`, `to_slow_o` and `to_fast_o` are 0. After reset, no strobe appears until the first cycle with `align_i` high.
- R2: `ratio_i` is an unsigned count of quarter fast periods per slow period, R = 4 x ratio, valid from 8 to 21. It is loaded only when `align_i` is sampled high. A value below 8 acts as 8 and a value above 21 acts as 21.
- R3: The fast cycle that begins at the edge where `align_i` is sampled high is cycle 0. `xfer_en_o` is high during cycle c exactly when c = floor(((2j+1)R + 3) / 8) for some j >= 0. This is the edge nearest the midpoint of slow cycle j, and on a tie the earlier edge is taken.
- R4: Each slow cycle gets exactly one strobe, one fast cycle wide. Two consecutive strobes are floor(R/4) or ceil(R/4) fast cycles apart.
- R5: The strobe pattern repeats every R fast cycles, which is four slow cycles. For R = 13 it repeats every 13 fast cycles.
- R6: `align_i` restarts the pattern at any point, whatever the current phase. `xfer_en_o` is low in cycle 0.
- R7: A change of `ratio_i` while `align_i` is low has no effect on the running pattern.
- R8: `to_slow_o` takes the value of `fast_din` at the end of every fast cycle in which `xfer_en_o` is high. In all other cycles it holds its value.
- R9: `to_fast_o` takes the value of `slow_din` at the end of every fast cycle in which `xfer_en_o` is high. In all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_i | input | 1 | Restarts the pattern and loads the ratio |
| ratio_i | input | RATIO_W (5) | Slow period in quarter fast periods |
| fast_din | input | DATA_W (16) | Fast-domain data bound for the slow side |
| slow_din | input | DATA_W (16) | Slow-domain data bound for the fast side |
| xfer_en_o | output | 1 | Crossing strobe, one per slow cycle |
| to_slow_o | output | DATA_W (16) | Fast-to-slow holding register |
| to_fast_o | output | DATA_W (16) | Slow-to-fast capture register |

## Verification
The assertions check the following on every cycle:
- the strobe is never two cycles wide;
- the spacing between strobes is one of the two allowed gaps, and the first strobe after an alignment comes after the right count;
- the active ratio stays in range and changes only at an alignment;
- both capture registers hold between strobes and load on a strobe.

Only the bench scenarios can show that each strobe lands on the exact cycle given by the midpoint formula. The same holds for tie handling, repetition after four slow cycles, clamping of out-of-range ratios and restart from an arbitrary phase. The bench compares these against an independent per-cycle computation for every legal ratio.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

   localparam int DEF_SUB_BITS  = 2;
   localparam int DEF_RATIO_MIN = 8;
   localparam int DEF_RATIO_MAX = 21;
   localparam int DEF_DATA_W    = 16;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } ph_state_e;

endpackage

// File: rtl/fxs_phase_track.sv
module fxs_phase_track
   import fxs_pkg::*;
#(
   parameter int SUB_BITS  = DEF_SUB_BITS,
   parameter int RATIO_MIN = DEF_RATIO_MIN,
   parameter int RATIO_MAX = DEF_RATIO_MAX,
   parameter int RATIO_W   = $clog2(RATIO_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               align,
   input  logic [RATIO_W-1:0] ratio_req,
   output logic               strobe
);

   // Positions are in units of 1/UNIT fast period, so midpoints are exact.
   localparam int UNIT  = 1 << (SUB_BITS + 1);
   localparam int HALF  = UNIT / 2;
   localparam int REM_W = $clog2(2 * RATIO_MAX + UNIT + 1) + 2;
   localparam logic signed [REM_W-1:0] UNIT_S = REM_W'(UNIT);
   localparam logic signed [REM_W-1:0] HALF_S = REM_W'(HALF);
   localparam logic [RATIO_W-1:0] RMIN_V = RATIO_W'(RATIO_MIN);
   localparam logic [RATIO_W-1:0] RMAX_V = RATIO_W'(RATIO_MAX);

   ph_state_e                 state_q;
   logic [RATIO_W-1:0]        ratio_act;
   logic [RATIO_W-1:0]        ratio_clamped;
   logic signed [REM_W-1:0]   rem_q;
   logic signed [REM_W-1:0]   rem_nxt;
   logic signed [REM_W-1:0]   ratio_s;
   logic                      fire;

   always_comb begin
      if (ratio_req < RMIN_V)      ratio_clamped = RMIN_V;
      else if (ratio_req > RMAX_V) ratio_clamped = RMAX_V;
      else                         ratio_clamped = ratio_req;
   end

   // rem_q: distance from the next fast edge to the pending slow midpoint.
   assign ratio_s = REM_W'(ratio_act);
   assign fire    = (state_q == PH_RUN) && (rem_q <= HALF_S);
   assign rem_nxt = rem_q - UNIT_S + (fire ? (ratio_s <<< 1) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PH_IDLE;
         ratio_act <= RMIN_V;
         rem_q     <= '0;
         strobe    <= 1'b0;
      end else if (align) begin
         state_q   <= PH_RUN;
         ratio_act <= ratio_clamped;
         rem_q     <= REM_W'(ratio_clamped) - UNIT_S;
         strobe    <= 1'b0;
      end else if (state_q == PH_RUN) begin
         strobe    <= fire;
         rem_q     <= rem_nxt;
      end
   end

   // Checker state: fast cycles since the last strobe or alignment.
   logic [RATIO_W-1:0] gap_cnt;
   logic               seen_q;
   logic [RATIO_W:0]   gap_lo;
   logic [RATIO_W:0]   gap_hi;
   logic [RATIO_W:0]   first_k;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= '0;
         seen_q  <= 1'b0;
      end else if (align) begin
         gap_cnt <= '0;
         seen_q  <= 1'b0;
      end else if (strobe) begin
         gap_cnt <= RATIO_W'(1);
         seen_q  <= 1'b1;
      end else if (gap_cnt != '1) begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

   assign gap_lo  = (RATIO_W+1)'(ratio_act) >> SUB_BITS;
   assign gap_hi  = ((RATIO_W+1)'(ratio_act) + (RATIO_W+1)'((1 << SUB_BITS) - 1)) >> SUB_BITS;
   assign first_k = ((RATIO_W+1)'(ratio_act) + (RATIO_W+1)'(HALF - 1)) >> (SUB_BITS + 1);

   a_r4_single_width: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   a_r4_gap_range: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && seen_q) |-> ((RATIO_W+1)'(gap_cnt) == gap_lo || (RATIO_W+1)'(gap_cnt) == gap_hi));

   a_r3_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !seen_q) |-> ((RATIO_W+1)'(gap_cnt) == first_k));

   a_r6_align_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      align |=> !strobe);

   a_r7_ratio_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !align |=> $stable(ratio_act));

   a_r2_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_act >= RMIN_V) && (ratio_act <= RMAX_V));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IDLE) |-> !strobe);

endmodule

// File: rtl/fxs_hold_reg.sv
module fxs_hold_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // Serves R8 (fast-to-slow instance) and R9 (slow-to-fast instance).
   a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   a_r9_load_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

endmodule

// File: rtl/frac_xing_strobe.sv
module frac_xing_strobe
   import fxs_pkg::*;
#(
   parameter int SUB_BITS  = DEF_SUB_BITS,
   parameter int RATIO_MIN = DEF_RATIO_MIN,
   parameter int RATIO_MAX = DEF_RATIO_MAX,
   parameter int DATA_W    = DEF_DATA_W,
   localparam int RATIO_W  = $clog2(RATIO_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               align_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic [DATA_W-1:0]  fast_din,
   input  logic [DATA_W-1:0]  slow_din,
   output logic               xfer_en_o,
   output logic [DATA_W-1:0]  to_slow_o,
   output logic [DATA_W-1:0]  to_fast_o
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (RATIO_MIN < (2 << SUB_BITS)) begin : g_bad_min
         $error("slow period must span at least two fast periods");
      end
      if (RATIO_MAX < RATIO_MIN) begin : g_bad_range
         $error("RATIO_MAX below RATIO_MIN");
      end
   endgenerate

   logic strobe;

   fxs_phase_track #(
      .SUB_BITS (SUB_BITS),
      .RATIO_MIN(RATIO_MIN),
      .RATIO_MAX(RATIO_MAX),
      .RATIO_W  (RATIO_W)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .align    (align_i),
      .ratio_req(ratio_i),
      .strobe   (strobe)
   );

   fxs_hold_reg #(.W(DATA_W)) u_to_slow (
      .clk  (clk),
      .rst_n(rst_n),
      .load (strobe),
      .d    (fast_din),
      .q    (to_slow_o)
   );

   fxs_hold_reg #(.W(DATA_W)) u_to_fast (
      .clk  (clk),
      .rst_n(rst_n),
      .load (strobe),
      .d    (slow_din),
      .q    (to_fast_o)
   );

   assign xfer_en_o = strobe;

endmodule

// File: tb/frac_xing_strobe_test.sv
module frac_xing_strobe_test;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          align_i = 1'b0;
   logic [4:0]    ratio_i = 5'd8;
   logic [DW-1:0] fast_din = '0;
   logic [DW-1:0] slow_din = '0;
   logic          xfer_en_o;
   logic [DW-1:0] to_slow_o;
   logic [DW-1:0] to_fast_o;

   int checks = 0;
   int errors = 0;
   int cur_r = 0;
   int cyc = 0;
   logic [DW-1:0] hold_f = '0;
   logic [DW-1:0] hold_s = '0;
   bit last_en;

   always #4 clk = ~clk;

   frac_xing_strobe uut (
      .clk(clk), .rst_n(rst_n), .align_i(align_i), .ratio_i(ratio_i),
      .fast_din(fast_din), .slow_din(slow_din),
      .xfer_en_o(xfer_en_o), .to_slow_o(to_slow_o), .to_fast_o(to_fast_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (ratio %0d cycle %0d)",
                  req, what, act, exp, cur_r, cyc);
      end
   endtask

   // Reference: strobe at fast cycle nearest each slow midpoint, ties earlier.
   function automatic bit ref_pulse(input int r, input int c);
      for (int j = 0; j < 1000; j++) begin
         int k;
         k = ((2 * j + 1) * r + 3) / 8;
         if (k == c) return 1'b1;
         if (k > c)  return 1'b0;
      end
      return 1'b0;
   endfunction

   function automatic int clamp_r(input int r);
      if (r < 8)  return 8;
      if (r > 21) return 21;
      return r;
   endfunction

   task automatic step(input string tag);
      bit exp_en;
      string dtag_f;
      string dtag_s;
      @(negedge clk);
      if (align_i) align_i = 1'b0;
      exp_en = (cur_r == 0) ? 1'b0 : ref_pulse(cur_r, cyc);
      dtag_f = (cur_r == 0) ? "R1" : "R8";
      dtag_s = (cur_r == 0) ? "R1" : "R9";
      check(xfer_en_o == exp_en, tag, "strobe", xfer_en_o, exp_en);
      check(to_slow_o == hold_f, dtag_f, "to_slow", to_slow_o, hold_f);
      check(to_fast_o == hold_s, dtag_s, "to_fast", to_fast_o, hold_s);
      last_en = xfer_en_o;
      fast_din = DW'(cyc * 37 + cur_r * 5 + 3);
      slow_din = DW'(16'hA5C3 ^ (cyc * 91 + cur_r));
      if (exp_en) begin
         hold_f = fast_din;
         hold_s = slow_din;
      end
      cyc++;
   endtask

   // Called at a falling edge; the next rising edge starts cycle 0.
   task automatic do_align(input int r);
      ratio_i = 5'(r);
      align_i = 1'b1;
      cur_r = clamp_r(r);
      cyc = 0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(xfer_en_o == 1'b0, "R1", "strobe in reset", xfer_en_o, 0);
      check(to_slow_o == '0, "R1", "to_slow in reset", to_slow_o, 0);
      check(to_fast_o == '0, "R1", "to_fast in reset", to_fast_o, 0);
      rst_n = 1'b1;
      cur_r = 0;
      for (int i = 0; i < 20; i++) step("R1");
   endtask

   task automatic t_all_ratios;
      for (int r = 8; r <= 21; r++) begin
         do_align(r);
         for (int i = 0; i < 3 * r + 5; i++) step(i == 0 ? "R6" : "R3");
      end
   endtask

   task automatic t_period13;
      bit seq [0:38];
      int cnt = 0;
      do_align(13);
      for (int i = 0; i < 39; i++) begin
         step("R4");
         seq[i] = last_en;
      end
      for (int i = 0; i < 13; i++) cnt += seq[i];
      check(cnt == 4, "R5", "strobes in 13 cycles", cnt, 4);
      for (int i = 0; i < 26; i++)
         check(seq[i] == seq[i + 13], "R5", "repeat after 13", seq[i + 13], seq[i]);
   endtask

   task automatic t_clamp;
      do_align(2);
      for (int i = 0; i < 30; i++) step("R2");
      do_align(30);
      for (int i = 0; i < 50; i++) step("R2");
   endtask

   task automatic t_ratio_change;
      do_align(10);
      for (int i = 0; i < 15; i++) step("R3");
      ratio_i = 5'd19;
      for (int i = 0; i < 40; i++) step("R7");
      ratio_i = 5'd9;
      for (int i = 0; i < 10; i++) step("R7");
      do_align(19);
      for (int i = 0; i < 45; i++) step("R7");
   endtask

   task automatic t_realign;
      do_align(17);
      for (int i = 0; i < 7; i++) step("R6");
      do_align(17);
      for (int i = 0; i < 40; i++) step("R6");
      do_align(11);
      for (int i = 0; i < 3; i++) step("R6");
      do_align(14);
      for (int i = 0; i < 40; i++) step("R6");
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_all_ratios();
      t_period13();
      t_clamp();
      t_ratio_change();
      t_realign();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule